// File: doc/BRIEF.md
# Bitwise Logic and Shift Unit

This block is the combinational logic-and-shift slice of a small 8-bit microcontroller datapath. In a single evaluation it takes two operands, a 4-bit operation code, the current carry and T flags and a bit index. It returns the result byte, a strobe that says whether the result should be written back, a status-flag vector, and a per-flag update mask. The surrounding datapath merges the flags into its status register under that mask.

The unit covers column-wise AND, OR and XOR, and one's complement. It also covers logical and arithmetic shifts, rotates through carry, and the exchange of the two nybbles. Two single-bit moves are included: one takes a chosen operand bit into T, and the other drops T into a chosen destination bit. Each operation updates only its own set of flags. The mask states exactly which flags those are.

Flag vector and mask bit positions: [0] C, [1] Z, [2] N, [3] V, [4] S, [5] H, [6] T. Operation codes: 0 AND, 1 OR, 2 XOR, 3 COM, 4 LSR, 5 LSL, 6 ASR, 7 ROR, 8 ROL, 9 SWAP, 10 BST, 11 BLD, 12–15 unused.

Top module: `bitops_unit`

## Requirements
- R1: Codes 0, 1 and 2 produce A AND B, A OR B and A XOR B bit by bit, with the write strobe high.
- R2: Code 3 produces the bitwise inverse of A with the write strobe high, and sets C to 1 with C in the mask.
- R3: For codes 0–3, Z is 1 exactly when the result is zero, N equals result bit 7, V is 0, and Z, N, V and S are in the mask. H and T are never in the mask, and C is in the mask only for code 3.
- R4: Code 4 (LSR) shifts A right and code 5 (LSL) shifts A left, filling the vacated bit with 0. The bit shifted out becomes C.
- R5: Code 6 (ASR) shifts A right while keeping bit 7, so 0xFB gives 0xFD. A bit 0 becomes C.
- R6: Code 7 (ROR) puts the incoming carry into bit 7, and code 8 (ROL) puts it into bit 0. The bit shifted out becomes C.
- R7: For codes 4–8, C, Z, N, V and S are in the mask, and V equals the new N XOR the new C. H is in the mask only for codes 5 and 8, where it equals A bit 3.
- R8: Code 9 exchanges the upper and lower nybbles of A with the write strobe high and an all-zero mask.
- R9: Code 10 (BST) drives T with A bit [index], holds the write strobe low, and puts only T in the mask.
- R10: Code 11 (BLD) returns A with bit [index] replaced by the incoming T, with the write strobe high and an all-zero mask.
- R11: Codes 12–15 hold the write strobe low and return an all-zero mask.
- R12: Every flag output whose mask bit is clear reads 0. Whenever S is in the mask, S equals N XOR V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code |
| opnd_a | input | 8 | First operand, and destination value for bit-load |
| opnd_b | input | 8 | Second operand for the two-operand logic codes |
| carry_in | input | 1 | Current carry flag |
| tbit_in | input | 1 | Current T flag |
| bit_idx | input | 3 | Bit position for BST and BLD |
| result | output | 8 | Result byte |
| result_we | output | 1 | Result write strobe |
| flags_out | output | 7 | New flag values {T,H,S,V,N,Z,C} |
| flags_upd | output | 7 | Flag update mask, same bit order |

## Verification
The assertions evaluate on every input change. They check the flag relations that must hold for any operand: S tracks N XOR V, Z tracks an all-zero result, and flags outside the mask read zero. They also check the mask and strobe shapes of swap and bit-store, and that the rotates take in the carry. Whether each result byte is the right shift, rotate, logic function or bit insertion can only be shown by the bench's scenarios. These sweep every operand byte with both carry values, and every bit index with both T values, against an independent model. They also cover the signed-shift example and the unused codes.

// File: rtl/bitops_pkg.sv
package bitops_pkg;

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_OR   = 4'd1,
    OP_XOR  = 4'd2,
    OP_COM  = 4'd3,
    OP_LSR  = 4'd4,
    OP_LSL  = 4'd5,
    OP_ASR  = 4'd6,
    OP_ROR  = 4'd7,
    OP_ROL  = 4'd8,
    OP_SWAP = 4'd9,
    OP_BST  = 4'd10,
    OP_BLD  = 4'd11
  } op_e;

  // flag vector positions
  localparam int unsigned FL_C = 0;
  localparam int unsigned FL_Z = 1;
  localparam int unsigned FL_N = 2;
  localparam int unsigned FL_V = 3;
  localparam int unsigned FL_S = 4;
  localparam int unsigned FL_H = 5;
  localparam int unsigned FL_T = 6;
  localparam int unsigned FL_COUNT = 7;

endpackage

// File: rtl/bitops_logic.sv
// Column-wise two-operand logic plus one's complement.
module bitops_logic
  import bitops_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);

  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: res = ~a;
    endcase
  end

endmodule

// File: rtl/bitops_shift.sv
// Shifts, rotates through carry and nybble exchange.
module bitops_shift
  import bitops_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic         c_in,
  output logic [W-1:0] res,
  output logic         c_out,
  output logic         h_out
);

  localparam int unsigned HALF = W / 2;

  always_comb begin
    res   = a;
    c_out = c_in;
    h_out = a[HALF-1];
    case (op)
      OP_LSR: begin
        res   = {1'b0, a[W-1:1]};
        c_out = a[0];
      end
      OP_LSL: begin
        res   = {a[W-2:0], 1'b0};
        c_out = a[W-1];
      end
      OP_ASR: begin
        res   = {a[W-1], a[W-1:1]};
        c_out = a[0];
      end
      OP_ROR: begin
        res   = {c_in, a[W-1:1]};
        c_out = a[0];
      end
      OP_ROL: begin
        res   = {a[W-2:0], c_in};
        c_out = a[W-1];
      end
      OP_SWAP: begin
        res = {a[HALF-1:0], a[W-1:HALF]};
      end
      default: begin
        res   = a;
        c_out = c_in;
      end
    endcase
  end

endmodule

// File: rtl/bitops_bitxfer.sv
// Single-bit moves between an operand bit and the T flag.
module bitops_bitxfer #(
  parameter int unsigned W    = 8,
  parameter int unsigned IDXW = $clog2(W)
) (
  input  logic [W-1:0]    a,
  input  logic [IDXW-1:0] idx,
  input  logic            t_in,
  output logic [W-1:0]    ins_res,
  output logic            t_out
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign ins_res[i] = (idx == IDXW'(i)) ? t_in : a[i];
  end

  assign t_out = a[idx];

endmodule

// File: rtl/bitops_unit.sv
// Top: operation steering, write strobe and flag/mask generation.
module bitops_unit
  import bitops_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter int unsigned IDXW = $clog2(W),
  parameter int unsigned NFL  = FL_COUNT
) (
  input  logic [3:0]      op_sel,
  input  logic [W-1:0]    opnd_a,
  input  logic [W-1:0]    opnd_b,
  input  logic            carry_in,
  input  logic            tbit_in,
  input  logic [IDXW-1:0] bit_idx,
  output logic [W-1:0]    result,
  output logic            result_we,
  output logic [NFL-1:0]  flags_out,
  output logic [NFL-1:0]  flags_upd
);

  op_e op;
  assign op = op_e'(op_sel);

  logic [W-1:0] logic_res;
  logic [W-1:0] shift_res;
  logic         shift_c;
  logic         shift_h;
  logic [W-1:0] xfer_res;
  logic         xfer_t;

  bitops_logic #(.W(W)) u_logic (
    .op  (op),
    .a   (opnd_a),
    .b   (opnd_b),
    .res (logic_res)
  );

  bitops_shift #(.W(W)) u_shift (
    .op    (op),
    .a     (opnd_a),
    .c_in  (carry_in),
    .res   (shift_res),
    .c_out (shift_c),
    .h_out (shift_h)
  );

  bitops_bitxfer #(.W(W), .IDXW(IDXW)) u_xfer (
    .a       (opnd_a),
    .idx     (bit_idx),
    .t_in    (tbit_in),
    .ins_res (xfer_res),
    .t_out   (xfer_t)
  );

  // steering: result source, strobe, mask and raw flag sources
  logic [W-1:0]   res_nxt;
  logic           we_nxt;
  logic [NFL-1:0] upd_nxt;
  logic           c_nxt;
  logic           h_nxt;
  logic           t_nxt;
  logic           is_shift;

  always_comb begin
    res_nxt  = opnd_a;
    we_nxt   = 1'b0;
    upd_nxt  = '0;
    c_nxt    = 1'b0;
    h_nxt    = 1'b0;
    t_nxt    = 1'b0;
    is_shift = 1'b0;
    case (op)
      OP_AND, OP_OR, OP_XOR: begin
        res_nxt = logic_res;
        we_nxt  = 1'b1;
        upd_nxt[FL_Z] = 1'b1;
        upd_nxt[FL_N] = 1'b1;
        upd_nxt[FL_V] = 1'b1;
        upd_nxt[FL_S] = 1'b1;
      end
      OP_COM: begin
        res_nxt = logic_res;
        we_nxt  = 1'b1;
        c_nxt   = 1'b1;
        upd_nxt[FL_C] = 1'b1;
        upd_nxt[FL_Z] = 1'b1;
        upd_nxt[FL_N] = 1'b1;
        upd_nxt[FL_V] = 1'b1;
        upd_nxt[FL_S] = 1'b1;
      end
      OP_LSR, OP_LSL, OP_ASR, OP_ROR, OP_ROL: begin
        res_nxt  = shift_res;
        we_nxt   = 1'b1;
        c_nxt    = shift_c;
        is_shift = 1'b1;
        upd_nxt[FL_C] = 1'b1;
        upd_nxt[FL_Z] = 1'b1;
        upd_nxt[FL_N] = 1'b1;
        upd_nxt[FL_V] = 1'b1;
        upd_nxt[FL_S] = 1'b1;
        if (op == OP_LSL || op == OP_ROL) begin
          h_nxt = shift_h;
          upd_nxt[FL_H] = 1'b1;
        end
      end
      OP_SWAP: begin
        res_nxt = shift_res;
        we_nxt  = 1'b1;
      end
      OP_BST: begin
        t_nxt = xfer_t;
        upd_nxt[FL_T] = 1'b1;
      end
      OP_BLD: begin
        res_nxt = xfer_res;
        we_nxt  = 1'b1;
      end
      default: begin
        res_nxt = opnd_a;
      end
    endcase
  end

  // derived flags from the selected result
  logic           n_val;
  logic           z_val;
  logic           v_val;
  logic           s_val;
  logic [NFL-1:0] flags_raw;

  always_comb begin
    n_val = res_nxt[W-1];
    z_val = (res_nxt == '0);
    v_val = is_shift ? (n_val ^ c_nxt) : 1'b0;
    s_val = n_val ^ v_val;
    flags_raw         = '0;
    flags_raw[FL_C]   = c_nxt;
    flags_raw[FL_Z]   = z_val;
    flags_raw[FL_N]   = n_val;
    flags_raw[FL_V]   = v_val;
    flags_raw[FL_S]   = s_val;
    flags_raw[FL_H]   = h_nxt;
    flags_raw[FL_T]   = t_nxt;
  end

  assign result    = res_nxt;
  assign result_we = we_nxt;
  assign flags_upd = upd_nxt;
  assign flags_out = flags_raw & upd_nxt;

endmodule

// File: rtl/bitops_unit_check.sv
// Property checker attached to the unit's ports.
module bitops_unit_check #(
  parameter int unsigned W    = 8,
  parameter int unsigned IDXW = $clog2(W),
  parameter int unsigned NFL  = 7
) (
  input logic [3:0]      op_sel,
  input logic [W-1:0]    opnd_a,
  input logic            carry_in,
  input logic [IDXW-1:0] bit_idx,
  input logic [W-1:0]    result,
  input logic            result_we,
  input logic [NFL-1:0]  flags_out,
  input logic [NFL-1:0]  flags_upd
);

  always_comb begin
    assert_s_tracks_nv_R12: assert (!flags_upd[4] ||
                                    (flags_out[4] == (flags_out[2] ^ flags_out[3])))
      else $error("S differs from N^V");
    assert_masked_zero_R12: assert ((flags_out & ~flags_upd) == '0)
      else $error("unmasked flag nonzero");
    assert_zero_flag_R3: assert (!flags_upd[1] || (flags_out[1] == (result == '0)))
      else $error("Z does not match result");
    assert_swap_noflags_R8: assert (op_sel != 4'd9 || (flags_upd == '0 && result_we))
      else $error("swap touched flags");
    assert_bst_shape_R9: assert (op_sel != 4'd10 ||
                                 (!result_we && flags_upd == 7'b1000000 &&
                                  flags_out[6] == opnd_a[bit_idx]))
      else $error("bit-store shape wrong");
    assert_rotate_cin_R6: assert (!(op_sel == 4'd7 && result[W-1] != carry_in) &&
                                  !(op_sel == 4'd8 && result[0] != carry_in))
      else $error("rotate lost carry");
    assert_unused_idle_R11: assert (op_sel < 4'd12 || (!result_we && flags_upd == '0))
      else $error("unused code active");
  end

endmodule

bind bitops_unit bitops_unit_check #(.W(W), .IDXW(IDXW), .NFL(NFL)) u_check (
  .op_sel    (op_sel),
  .opnd_a    (opnd_a),
  .carry_in  (carry_in),
  .bit_idx   (bit_idx),
  .result    (result),
  .result_we (result_we),
  .flags_out (flags_out),
  .flags_upd (flags_upd)
);

// File: tb/tb_bitops_unit.sv
module tb_bitops_unit;

  logic       clk;
  logic [3:0] op_sel;
  logic [7:0] opnd_a, opnd_b;
  logic       carry_in, tbit_in;
  logic [2:0] bit_idx;
  logic [7:0] result;
  logic       result_we;
  logic [6:0] flags_out, flags_upd;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  bitops_unit dut (
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .carry_in(carry_in), .tbit_in(tbit_in), .bit_idx(bit_idx),
    .result(result), .result_we(result_we),
    .flags_out(flags_out), .flags_upd(flags_upd)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, got %0d cycles expected < 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  // reference model built from the requirement list
  task automatic model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic c, input logic t, input logic [2:0] ix,
                       output logic [7:0] r, output logic we,
                       output logic [6:0] fl, output logic [6:0] up);
    logic cn, hn, tn, n, z, v, s;
    bit sh;
    r = a; we = 0; up = 0; cn = 0; hn = 0; tn = 0; sh = 0;
    case (op)
      4'd0: begin r = a & b; we = 1; up = 7'b0011110; end
      4'd1: begin r = a | b; we = 1; up = 7'b0011110; end
      4'd2: begin r = a ^ b; we = 1; up = 7'b0011110; end
      4'd3: begin r = 8'hFF - a; we = 1; up = 7'b0011111; cn = 1; end
      4'd4: begin r = a >> 1; cn = a[0]; sh = 1; end
      4'd5: begin r = a << 1; cn = a[7]; sh = 1; hn = a[3]; end
      4'd6: begin r = 8'($signed(a) >>> 1); cn = a[0]; sh = 1; end
      4'd7: begin r = (a >> 1) | (c ? 8'h80 : 8'h00); cn = a[0]; sh = 1; end
      4'd8: begin r = (a << 1) | {7'd0, c}; cn = a[7]; sh = 1; hn = a[3]; end
      4'd9: begin r = {a[3:0], a[7:4]}; we = 1; end
      4'd10: begin tn = a[ix]; up = 7'b1000000; end
      4'd11: begin r = a; r[ix] = t; we = 1; end
      default: ;
    endcase
    if (sh) begin
      we = 1;
      up = (op == 4'd5 || op == 4'd8) ? 7'b0111111 : 7'b0011111;
    end
    n = r[7];
    z = (r == 8'd0);
    v = sh ? (n ^ cn) : 1'b0;
    s = n ^ v;
    fl = {tn, hn, s, v, n, z, cn} & up;
  endtask

  task automatic apply(input string tag, input logic [3:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic c, input logic t,
                       input logic [2:0] ix);
    logic [7:0] er; logic ew; logic [6:0] ef, eu;
    op_sel = op; opnd_a = a; opnd_b = b; carry_in = c; tbit_in = t; bit_idx = ix;
    #1;
    model(op, a, b, c, t, ix, er, ew, ef, eu);
    n_chk++;
    if (result !== er || result_we !== ew || flags_out !== ef || flags_upd !== eu) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h c=%b t=%b ix=%0d: got r=%h we=%b f=%b u=%b expected r=%h we=%b f=%b u=%b",
               tag, op, a, b, c, t, ix, result, result_we, flags_out, flags_upd,
               er, ew, ef, eu);
    end
    #1;
  endtask

  task automatic sweep_one(input string tag, input logic [3:0] op);
    for (int a = 0; a < 256; a++)
      for (int c = 0; c < 2; c++)
        apply(tag, op, 8'(a), 8'(a * 37 + 5), c[0], 1'b0, 3'd0);
  endtask

  task automatic t_idle;  // R11: unused codes, checked first as the rest state
    for (int op = 12; op < 16; op++)
      for (int a = 0; a < 256; a += 17)
        apply("R11", 4'(op), 8'(a), 8'h5A, 1'b1, 1'b1, 3'd3);
  endtask

  task automatic t_logic;  // R1, R3
    for (int op = 0; op < 3; op++)
      for (int a = 0; a < 256; a++)
        for (int bi = 0; bi < 8; bi++)
          apply("R1", 4'(op), 8'(a), 8'(8'h0F << bi) ^ 8'(bi * 51), a[0], a[1], 3'd0);
    apply("R3", 4'd0, 8'hF0, 8'h0F, 1'b1, 1'b1, 3'd0);
    apply("R3", 4'd1, 8'h80, 8'h00, 1'b0, 1'b0, 3'd0);
  endtask

  task automatic t_com;  // R2
    sweep_one("R2", 4'd3);
    apply("R2", 4'd3, 8'hFF, 8'h00, 1'b0, 1'b0, 3'd0);
  endtask

  task automatic t_logical_shift;  // R4, R7
    sweep_one("R4", 4'd4);
    sweep_one("R7", 4'd5);
    apply("R4", 4'd4, 8'h01, 8'h00, 1'b1, 1'b0, 3'd0);
    apply("R7", 4'd5, 8'h88, 8'h00, 1'b0, 1'b0, 3'd0);
  endtask

  task automatic t_asr;  // R5
    sweep_one("R5", 4'd6);
    apply("R5", 4'd6, 8'hFB, 8'h00, 1'b0, 1'b0, 3'd0);
    n_chk++;
    if (result !== 8'hFD) begin
      n_fail++;
      $display("FAIL R5 signed example: got %h expected FD", result);
    end
  endtask

  task automatic t_rotate;  // R6, R12
    sweep_one("R6", 4'd7);
    sweep_one("R6", 4'd8);
    apply("R12", 4'd7, 8'h00, 8'h00, 1'b1, 1'b0, 3'd0);
  endtask

  task automatic t_swap;  // R8
    sweep_one("R8", 4'd9);
  endtask

  task automatic t_bits;  // R9, R10
    for (int ix = 0; ix < 8; ix++)
      for (int t = 0; t < 2; t++)
        for (int a = 0; a < 256; a += 5) begin
          apply("R9", 4'd10, 8'(a), 8'h00, 1'b1, t[0], 3'(ix));
          apply("R10", 4'd11, 8'(a), 8'h00, 1'b1, t[0], 3'(ix));
        end
  endtask

  initial begin
    op_sel = 4'd15; opnd_a = 0; opnd_b = 0; carry_in = 0; tbit_in = 0; bit_idx = 0;
    #3;
    t_idle();
    t_logic();
    t_com();
    t_logical_shift();
    t_asr();
    t_rotate();
    t_swap();
    t_bits();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule